// File: doc/BRIEF.md
# Address/Data Write Router

This block sits in a small controller's general register file, behind two address registers and one data register. The first address register is the normal one and the second is the user one. Software writes one of them with a target, then writes the data register one or more times. Each data write is sent either to a device register or to a pipe register. The choice depends on how the active address decodes. After each data write the active address steps forward, so a burst of data writes lands on consecutive targets with no further address writes.

A two-state machine records which address register is active. It starts in `SRC_NORM`. A write to the user address register moves it to `SRC_USER`. A write to the normal address register moves it back to `SRC_NORM`. Any other write leaves the state unchanged.

An address above 0xFFFF names a pipe register. Its 8-bit index sits in bits 31:24, and bit 18 stops the index from advancing. Three pipe indices form a streaming memory writer: two of them hold a 64-bit byte address, and the third sends a 32-bit word to memory at that address. The remaining general register indices are plain storage, and index 0 reads as zero.

Top module: `addr_data_router`

## Requirements
- R1: A write to index 20 (normal address) or index 21 (user address) stores the value and makes that register the source for later data writes at index 22. `user_active` is 1 when the user register is the source.
- R2: An address above 0xFFFF is a pipe address with index bits 31:24. A data write through a legal pipe address pulses `pipe_we` for one cycle, with that index and the written data, in the cycle after the write.
- R3: An address write with a legal pipe value whose index is data-less (indices 0x30 and 0x31) issues a pipe write of zero to that index in the next cycle.
- R4: A data write through a legal pipe address adds 0x01000000 to the active address, with 32-bit wrap, unless bit 18 is set. This step never causes the data-less write of R3.
- R5: A data write through a non-pipe address pulses `dev_we` with offset equal to the address and the written data, and adds one to the active address.
- R6: A non-pipe offset of 4096 or above produces no `dev_we`, but the active address still advances by one.
- R7: A pipe address with any bit of 0x00FBFFFF set is illegal. A data write through it makes no pipe or device write and leaves the address unchanged. An address write of such a value issues no data-less write. Both cases set `addr_fault`, which stays set until reset.
- R8: Pipe writes to index 0x10 and index 0x11 load the low and high words of a 64-bit address. A pipe write to index 0x12 pulses `mem_we` with that address and the data, then adds 4 to the address with carry into the high word.
- R9: A read of index 0 or index 22 returns zero. Reads of indices 20 and 21 return the current address registers. Any other index returns the value last written to it.
- R10: After reset every strobe, `addr_fault` and `user_active` are 0, and every register reads 0. Write effects appear only in the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpr_we | input | 1 | Register write strobe |
| gpr_widx | input | 5 | Register write index |
| gpr_wdata | input | 32 | Register write data |
| gpr_ridx | input | 5 | Register read index |
| gpr_rdata | output | 32 | Register read data (combinational) |
| dev_we | output | 1 | Device register write strobe |
| dev_offs | output | 12 | Device register offset |
| dev_wdata | output | 32 | Device register write data |
| pipe_we | output | 1 | Pipe register write strobe |
| pipe_idx | output | 8 | Pipe register index |
| pipe_wdata | output | 32 | Pipe register write data |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| addr_fault | output | 1 | Sticky illegal pipe address flag |
| user_active | output | 1 | User address register is the source |

## Verification
Data bursts run through both address registers in turn. This shows whether each source keeps its own running address across source switches.

Pipe bursts are run both with and without bit 18. The incrementing burst shows the index stepping, the wrap past 0xFF and the missing data-less write after a step. The non-incrementing burst streams to memory and shows the 4-byte advance and the carry into the high word.

Offsets at 0xFFF, 0x1000 and 0xFFFF bound the device range, and the last one steps into an illegal pipe address. Illegal values are written both as addresses and as targets of data writes, to separate fault setting from write suppression.

// File: rtl/adr_pkg.sv
package adr_pkg;

    typedef enum logic {
        SRC_NORM = 1'b0,
        SRC_USER = 1'b1
    } src_e;

    typedef struct packed {
        logic        is_pipe;
        logic        legal;
        logic        no_inc;
        logic [7:0]  pidx;
        logic [15:0] offs;
    } addr_info_t;

    localparam logic [31:0] PIPE_STEP     = 32'h0100_0000;
    localparam logic [31:0] PIPE_BAD_BITS = 32'h00FB_FFFF;
    localparam logic [31:0] DEV_LIMIT     = 32'h0000_FFFF;
    localparam int          NO_INC_BIT    = 18;

endpackage

// File: rtl/adr_decode.sv
module adr_decode
    import adr_pkg::*;
(
    input  logic [31:0] addr,
    output addr_info_t  info
);

    always_comb begin
        info.is_pipe = (addr > DEV_LIMIT);
        info.legal   = !info.is_pipe || ((addr & PIPE_BAD_BITS) == 32'h0);
        info.no_inc  = addr[NO_INC_BIT];
        info.pidx    = addr[31:24];
        info.offs    = addr[15:0];
    end

endmodule

// File: rtl/adr_gpr_store.sv
module adr_gpr_store #(
    parameter int IDX_W   = 5,
    parameter int NUM_GPR = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata
);

    logic [NUM_GPR-1:0][31:0] regs_q;

    generate
        for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
            if (g == 0) begin : g_zero
                assign regs_q[g] = 32'h0;
            end else begin : g_flop
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        regs_q[g] <= 32'h0;
                    end else if (we && (widx == IDX_W'(g))) begin
                        regs_q[g] <= wdata;
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        rdata = 32'h0;
        if (int'(ridx) < NUM_GPR) begin
            rdata = regs_q[ridx];
        end
    end

endmodule

// File: rtl/adr_stream_mem.sv
module adr_stream_mem #(
    parameter int LO_IDX   = 8'h10,
    parameter int HI_IDX   = 8'h11,
    parameter int DATA_IDX = 8'h12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pw_we,
    input  logic [7:0]  pw_idx,
    input  logic [31:0] pw_data,
    output logic        mem_we,
    output logic [63:0] mem_addr,
    output logic [31:0] mem_wdata
);

    localparam logic [7:0] I_LO   = 8'(LO_IDX);
    localparam logic [7:0] I_HI   = 8'(HI_IDX);
    localparam logic [7:0] I_DATA = 8'(DATA_IDX);

    logic [63:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= 64'h0;
            mem_we    <= 1'b0;
            mem_addr  <= 64'h0;
            mem_wdata <= 32'h0;
        end else begin
            mem_we <= 1'b0;
            if (pw_we) begin
                if (pw_idx == I_LO) begin
                    base_q[31:0] <= pw_data;
                end else if (pw_idx == I_HI) begin
                    base_q[63:32] <= pw_data;
                end else if (pw_idx == I_DATA) begin
                    mem_we    <= 1'b1;
                    mem_addr  <= base_q;
                    mem_wdata <= pw_data;
                    base_q    <= base_q + 64'd4;
                end
            end
        end
    end

    p_stream_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pw_we && pw_idx == I_DATA) |=> (base_q == $past(base_q) + 64'd4) && mem_we);

    p_stream_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pw_we && pw_idx == I_DATA) |=> !mem_we);

endmodule

// File: rtl/addr_data_router.sv
module addr_data_router
    import adr_pkg::*;
#(
    parameter int           IDX_W           = 5,
    parameter int           NUM_GPR         = 32,
    parameter int           NORM_ADDR_IDX   = 20,
    parameter int           USER_ADDR_IDX   = 21,
    parameter int           DATA_IDX        = 22,
    parameter int           DEV_REGS        = 4096,
    parameter int           STREAM_LO_IDX   = 8'h10,
    parameter int           STREAM_HI_IDX   = 8'h11,
    parameter int           STREAM_DATA_IDX = 8'h12,
    parameter logic [255:0] QUIET_PIPE_MASK = (256'd1 << 8'h30) | (256'd1 << 8'h31)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          gpr_we,
    input  logic [IDX_W-1:0]              gpr_widx,
    input  logic [31:0]                   gpr_wdata,
    input  logic [IDX_W-1:0]              gpr_ridx,
    output logic [31:0]                   gpr_rdata,
    output logic                          dev_we,
    output logic [$clog2(DEV_REGS)-1:0]   dev_offs,
    output logic [31:0]                   dev_wdata,
    output logic                          pipe_we,
    output logic [7:0]                    pipe_idx,
    output logic [31:0]                   pipe_wdata,
    output logic                          mem_we,
    output logic [63:0]                   mem_addr,
    output logic [31:0]                   mem_wdata,
    output logic                          addr_fault,
    output logic                          user_active
);

    localparam int               DEV_AW = $clog2(DEV_REGS);
    localparam logic [IDX_W-1:0] IX_NA  = IDX_W'(NORM_ADDR_IDX);
    localparam logic [IDX_W-1:0] IX_UA  = IDX_W'(USER_ADDR_IDX);
    localparam logic [IDX_W-1:0] IX_DT  = IDX_W'(DATA_IDX);

    src_e        state_q, state_d;
    logic [31:0] addr_norm_q, addr_user_q;
    logic [31:0] addr_norm_d, addr_user_d;
    logic [31:0] act_addr, act_next;
    logic        wr_norm, wr_user, wr_data, wr_plain;
    addr_info_t  info_w, info_a;
    logic        dev_req, dev_in_range;
    logic        pw_req;
    logic [7:0]  pw_idx_c;
    logic [31:0] pw_data_c;
    logic        fault_set;
    logic [31:0] store_rdata;

    assign wr_norm  = gpr_we && (gpr_widx == IX_NA);
    assign wr_user  = gpr_we && (gpr_widx == IX_UA);
    assign wr_data  = gpr_we && (gpr_widx == IX_DT);
    assign wr_plain = gpr_we && !wr_norm && !wr_user && !wr_data;
    assign act_addr = (state_q == SRC_USER) ? addr_user_q : addr_norm_q;

    adr_decode u_dec_wr  (.addr(gpr_wdata), .info(info_w));
    adr_decode u_dec_act (.addr(act_addr),  .info(info_a));

    // Source-select state machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_NORM: if (wr_user) state_d = SRC_USER;
            SRC_USER: if (wr_norm) state_d = SRC_NORM;
            default:  state_d = SRC_NORM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_NORM;
        else        state_q <= state_d;
    end

    // Target routing and address stepping
    always_comb begin
        dev_in_range = (32'(info_a.offs) < DEV_REGS);
        dev_req      = 1'b0;
        pw_req       = 1'b0;
        pw_idx_c     = 8'h0;
        pw_data_c    = 32'h0;
        fault_set    = 1'b0;
        act_next     = act_addr;
        if (wr_norm || wr_user) begin
            if (info_w.is_pipe && !info_w.legal) begin
                fault_set = 1'b1;
            end else if (info_w.is_pipe && QUIET_PIPE_MASK[info_w.pidx]) begin
                pw_req   = 1'b1;
                pw_idx_c = info_w.pidx;
            end
        end else if (wr_data) begin
            if (info_a.is_pipe) begin
                if (!info_a.legal) begin
                    fault_set = 1'b1;
                end else begin
                    pw_req    = 1'b1;
                    pw_idx_c  = info_a.pidx;
                    pw_data_c = gpr_wdata;
                    if (!info_a.no_inc) act_next = act_addr + PIPE_STEP;
                end
            end else begin
                dev_req  = dev_in_range;
                act_next = act_addr + 32'd1;
            end
        end
    end

    always_comb begin
        addr_norm_d = addr_norm_q;
        addr_user_d = addr_user_q;
        if (wr_norm) begin
            addr_norm_d = gpr_wdata;
        end else if (wr_user) begin
            addr_user_d = gpr_wdata;
        end else if (wr_data) begin
            if (state_q == SRC_USER) addr_user_d = act_next;
            else                     addr_norm_d = act_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_norm_q <= 32'h0;
            addr_user_q <= 32'h0;
        end else begin
            addr_norm_q <= addr_norm_d;
            addr_user_q <= addr_user_d;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_we     <= 1'b0;
            dev_offs   <= '0;
            dev_wdata  <= 32'h0;
            pipe_we    <= 1'b0;
            pipe_idx   <= 8'h0;
            pipe_wdata <= 32'h0;
            addr_fault <= 1'b0;
        end else begin
            dev_we  <= dev_req;
            pipe_we <= pw_req;
            if (dev_req) begin
                dev_offs  <= info_a.offs[DEV_AW-1:0];
                dev_wdata <= gpr_wdata;
            end
            if (pw_req) begin
                pipe_idx   <= pw_idx_c;
                pipe_wdata <= pw_data_c;
            end
            if (fault_set) addr_fault <= 1'b1;
        end
    end

    assign user_active = (state_q == SRC_USER);

    adr_stream_mem #(
        .LO_IDX   (STREAM_LO_IDX),
        .HI_IDX   (STREAM_HI_IDX),
        .DATA_IDX (STREAM_DATA_IDX)
    ) u_stream (
        .clk       (clk),
        .rst_n     (rst_n),
        .pw_we     (pw_req),
        .pw_idx    (pw_idx_c),
        .pw_data   (pw_data_c),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    adr_gpr_store #(
        .IDX_W   (IDX_W),
        .NUM_GPR (NUM_GPR)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_plain),
        .widx  (gpr_widx),
        .wdata (gpr_wdata),
        .ridx  (gpr_ridx),
        .rdata (store_rdata)
    );

    always_comb begin
        if (gpr_ridx == IX_NA)       gpr_rdata = addr_norm_q;
        else if (gpr_ridx == IX_UA)  gpr_rdata = addr_user_q;
        else if (gpr_ridx == IX_DT)  gpr_rdata = 32'h0;
        else                         gpr_rdata = store_rdata;
    end

    // Checks
    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dev_we, pipe_we}));

    p_src_user_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_user |=> user_active);

    p_src_norm_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_norm |=> !user_active);

    p_pipe_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && state_q == SRC_NORM && info_a.is_pipe && info_a.legal && !info_a.no_inc)
        |=> (addr_norm_q == $past(addr_norm_q) + PIPE_STEP));

    p_dev_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && state_q == SRC_NORM && !info_a.is_pipe)
        |=> (addr_norm_q == $past(addr_norm_q) + 32'd1));

    p_dev_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !info_a.is_pipe && 32'(info_a.offs) >= DEV_REGS) |=> !dev_we);

    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        addr_fault |=> addr_fault);

    p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && info_a.is_pipe && !info_a.legal)
        |=> (!pipe_we && !dev_we && addr_fault && $stable(addr_norm_q) && $stable(addr_user_q)));

endmodule

// File: tb/addr_data_router_bench.sv
`timescale 1ns/1ps
module addr_data_router_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gpr_we = 1'b0;
    logic [4:0]  gpr_widx = 5'd0;
    logic [31:0] gpr_wdata = 32'h0;
    logic [4:0]  gpr_ridx = 5'd0;
    logic [31:0] gpr_rdata;
    logic        dev_we;
    logic [11:0] dev_offs;
    logic [31:0] dev_wdata;
    logic        pipe_we;
    logic [7:0]  pipe_idx;
    logic [31:0] pipe_wdata;
    logic        mem_we;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        addr_fault;
    logic        user_active;

    always #4 clk = ~clk;

    addr_data_router u_addr_data_router (
        .clk(clk), .rst_n(rst_n), .gpr_we(gpr_we), .gpr_widx(gpr_widx),
        .gpr_wdata(gpr_wdata), .gpr_ridx(gpr_ridx), .gpr_rdata(gpr_rdata),
        .dev_we(dev_we), .dev_offs(dev_offs), .dev_wdata(dev_wdata),
        .pipe_we(pipe_we), .pipe_idx(pipe_idx), .pipe_wdata(pipe_wdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .addr_fault(addr_fault), .user_active(user_active)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural reference model
    logic [31:0] m_addr [2];
    logic [31:0] m_gpr  [32];
    logic        m_user = 1'b0;
    logic        m_fault = 1'b0;
    logic [63:0] m_base = 64'h0;
    logic        e_dev_we = 1'b0, e_pipe_we = 1'b0, e_mem_we = 1'b0;
    logic [11:0] e_dev_offs = 12'h0;
    logic [31:0] e_dev_wdata = 32'h0, e_pipe_wdata = 32'h0, e_mem_wdata = 32'h0;
    logic [7:0]  e_pipe_idx = 8'h0;
    logic [63:0] e_mem_addr = 64'h0;

    initial begin
        m_addr[0] = 32'h0;
        m_addr[1] = 32'h0;
        for (int i = 0; i < 32; i++) m_gpr[i] = 32'h0;
    end

    function automatic bit quiet_idx(input logic [7:0] i);
        return (i == 8'h30) || (i == 8'h31);
    endfunction

    task automatic model_pipe(input logic [7:0] i, input logic [31:0] d);
        e_pipe_we = 1'b1;
        e_pipe_idx = i;
        e_pipe_wdata = d;
        if (i == 8'h10) m_base[31:0] = d;
        else if (i == 8'h11) m_base[63:32] = d;
        else if (i == 8'h12) begin
            e_mem_we = 1'b1;
            e_mem_addr = m_base;
            e_mem_wdata = d;
            m_base = m_base + 64'd4;
        end
    endtask

    always @(posedge clk) begin
        logic [31:0] a;
        e_dev_we = 1'b0;
        e_pipe_we = 1'b0;
        e_mem_we = 1'b0;
        if (!rst_n) begin
            m_addr[0] = 32'h0;
            m_addr[1] = 32'h0;
            m_user = 1'b0;
            m_fault = 1'b0;
            m_base = 64'h0;
            for (int i = 0; i < 32; i++) m_gpr[i] = 32'h0;
        end else if (gpr_we) begin
            if (gpr_widx == 5'd20 || gpr_widx == 5'd21) begin
                m_user = (gpr_widx == 5'd21);
                m_addr[m_user] = gpr_wdata;
                if (gpr_wdata > 32'hFFFF) begin
                    if ((gpr_wdata & 32'h00FBFFFF) != 0) m_fault = 1'b1;
                    else if (quiet_idx(gpr_wdata[31:24])) model_pipe(gpr_wdata[31:24], 32'h0);
                end
            end else if (gpr_widx == 5'd22) begin
                a = m_addr[m_user];
                if (a > 32'hFFFF) begin
                    if ((a & 32'h00FBFFFF) != 0) m_fault = 1'b1;
                    else begin
                        if (!a[18]) m_addr[m_user] = a + 32'h0100_0000;
                        model_pipe(a[31:24], gpr_wdata);
                    end
                end else begin
                    if (a < 32'd4096) begin
                        e_dev_we = 1'b1;
                        e_dev_offs = a[11:0];
                        e_dev_wdata = gpr_wdata;
                    end
                    m_addr[m_user] = a + 32'd1;
                end
            end else if (gpr_widx != 5'd0) begin
                m_gpr[gpr_widx] = gpr_wdata;
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [4:0] r);
        if (r == 5'd20) return m_addr[0];
        if (r == 5'd21) return m_addr[1];
        if (r == 5'd22 || r == 5'd0) return 32'h0;
        return m_gpr[r];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check(dev_we == e_dev_we, "R5/R6/R10", "dev_we", 64'(dev_we), 64'(e_dev_we));
            if (e_dev_we && dev_we)
                check(dev_offs == e_dev_offs && dev_wdata == e_dev_wdata, "R5", "dev offs/data",
                      {20'h0, dev_offs, dev_wdata}, {20'h0, e_dev_offs, e_dev_wdata});
            check(pipe_we == e_pipe_we, "R2/R3/R4", "pipe_we", 64'(pipe_we), 64'(e_pipe_we));
            if (e_pipe_we && pipe_we)
                check(pipe_idx == e_pipe_idx && pipe_wdata == e_pipe_wdata, "R2/R3", "pipe idx/data",
                      {24'h0, pipe_idx, pipe_wdata}, {24'h0, e_pipe_idx, e_pipe_wdata});
            check(mem_we == e_mem_we, "R8", "mem_we", 64'(mem_we), 64'(e_mem_we));
            if (e_mem_we && mem_we) begin
                check(mem_addr == e_mem_addr, "R8", "mem_addr", mem_addr, e_mem_addr);
                check(mem_wdata == e_mem_wdata, "R8", "mem_wdata", 64'(mem_wdata), 64'(e_mem_wdata));
            end
            check(addr_fault == m_fault, "R7", "addr_fault", 64'(addr_fault), 64'(m_fault));
            check(user_active == m_user, "R1", "user_active", 64'(user_active), 64'(m_user));
            check(gpr_rdata == model_read(gpr_ridx), "R9", "gpr_rdata",
                  64'(gpr_rdata), 64'(model_read(gpr_ridx)));
            gpr_ridx = gpr_ridx + 5'd1;
        end
    end

    task automatic wr(input logic [4:0] i, input logic [31:0] d);
        @(negedge clk);
        gpr_we = 1'b1;
        gpr_widx = i;
        gpr_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            gpr_we = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(!dev_we && !pipe_we && !mem_we && !addr_fault && !user_active, "R10",
              "reset outputs", {59'h0, dev_we, pipe_we, mem_we, addr_fault, user_active}, 64'h0);
        idle(33);
        // R9: plain storage
        wr(5'd5, 32'hDEAD_BEEF);
        wr(5'd0, 32'h1234_5678);
        wr(5'd31, 32'hCAFE_0001);
        idle(34);
        // R5: device burst on normal source
        wr(5'd20, 32'h0000_0100);
        wr(5'd22, 32'hA0);
        wr(5'd22, 32'hA1);
        wr(5'd22, 32'hA2);
        idle(2);
        // R1/R6: user source across device range edge
        wr(5'd21, 32'h0000_0FFF);
        wr(5'd22, 32'hB0);
        wr(5'd22, 32'hB1);
        wr(5'd20, 32'h0000_0103);
        wr(5'd22, 32'hC0);
        idle(2);
        // R2/R4/R8: incrementing pipe burst loads stream address
        wr(5'd20, 32'h1000_0000);
        wr(5'd22, 32'hFFFF_FFF8);
        wr(5'd22, 32'h0000_0001);
        wr(5'd22, 32'h5555_0000);
        idle(2);
        // R8: non-incrementing stream with carry
        wr(5'd21, 32'h1204_0000);
        wr(5'd22, 32'h1111_1111);
        wr(5'd22, 32'h2222_2222);
        wr(5'd22, 32'h3333_3333);
        idle(2);
        // R3/R4: data-less on address write, not on step
        wr(5'd20, 32'h3000_0000);
        wr(5'd20, 32'h2F00_0000);
        wr(5'd22, 32'h77);
        wr(5'd22, 32'h78);
        idle(2);
        // R4: index wrap
        wr(5'd20, 32'hFF00_0000);
        wr(5'd22, 32'h99);
        wr(5'd22, 32'h9A);
        idle(34);
        // R7: illegal address write, then illegal data target
        wr(5'd20, 32'h3000_0001);
        idle(2);
        wr(5'd22, 32'hEE);
        idle(2);
        wr(5'd21, 32'h0000_FFFF);
        wr(5'd22, 32'hF0);
        wr(5'd22, 32'hF1);
        wr(5'd20, 32'h0000_0200);
        wr(5'd22, 32'hF2);
        idle(34);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule